// File: doc/BRIEF.md
# Locking 24-bit serial frame receiver

This block takes write frames from a three-wire serial link (an active-low frame select, a serial clock and a data line) and turns each complete frame into one 24-bit word for a downstream command decoder. All three serial lines are brought into the system clock domain through two-flop synchronisers. Falling edges of select and of the serial clock are then detected from the synchronised levels.

A frame opens on a falling edge of select. The data line is sampled on every falling serial-clock edge, and the first bit lands in the word's most significant position. On the 24th falling edge the word is delivered at once with a one-cycle strobe, and the frame locks: further clock edges are ignored until select rises and falls again. If select rises before the 24th edge, the partial frame is thrown away, nothing is delivered and the previously delivered word stays on the output.

The system clock must run at least four times faster than the serial clock. Each serial event reaches the outputs three system cycles after it occurs on the pins: two synchroniser stages plus the edge register.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `word_o` is 0, `word_valid_o` is 0 and `busy_o` is 0.
- R2: Bits are taken MSB first. The bit sampled at the first falling serial-clock edge of a frame appears in `word_o[23]`, and the bit sampled at the 24th edge appears in `word_o[0]`.
- R3: On the 24th falling serial-clock edge of a frame, `word_valid_o` is high for exactly one system cycle. `word_o` carries the new word in that cycle and holds it until the next completed frame.
- R4: Delivery does not wait for select to rise. The strobe arrives while select is still low, three system cycles after the 24th falling edge reaches the pins.
- R5: Serial-clock edges after the 24th in the same frame change neither `word_o` nor the strobe.
- R6: If select rises before the 24th falling edge, no strobe is given, `word_o` keeps its previous value, and the next frame is received as if the aborted bits had never been sent.
- R7: A new frame starts only on a falling edge of select. Serial-clock edges while select is high, or while a completed frame is held with select low, produce no strobe.
- R8: `busy_o` goes high three system cycles after select falls and stays high until the frame completes (the strobe cycle) or aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Frame select from the serial link, active low |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| word_o | output | 24 | Last completed word |
| word_valid_o | output | 1 | One-cycle strobe marking a newly completed word |
| busy_o | output | 1 | High while a frame is being received |

## Verification
The checker watches several properties on every cycle. The strobe is never longer than one cycle, and the output word changes only with it. An abort is never followed by a strobe. The busy flag rises only after a select fall and drops only on completion or abort. The bit counter stays in range and is zero outside a frame. Only the directed scenarios can show that the delivered word equals the bits sent, in MSB-first order, and that the strobe comes at the expected cycle with select still low. The same applies to ignoring trailing clocks and clocks while idle, and to leaving no trace of an aborted frame in the next word.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_LOCKED = 2'd2
  } sfr_state_t;

  // Append one serial bit at the LSB end of a partial word (MSB-first link).
  function automatic logic [23:0] shift_in(input logic [23:0] cur, input logic bit_in);
    return {cur[22:0], bit_in};
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          LINES   = 3,
  parameter int          STAGES  = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/sfr_fall_det.sv
module sfr_fall_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
  import sfr_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_lvl_i,
  input  logic             sel_fall_i,
  input  logic             sclk_fall_i,
  output logic             shift_en_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] bit_cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  sfr_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_shift;

  assign in_shift   = (state_q == ST_SHIFT);
  // A rising select wins over a coincident clock edge.
  assign abort_o    = in_shift & sel_lvl_i;
  assign shift_en_o = in_shift & ~sel_lvl_i & sclk_fall_i;
  assign done_o     = shift_en_o & (cnt_q == LAST_BIT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_fall_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (abort_o) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (done_o) begin
          state_d = ST_LOCKED;
          cnt_d   = '0;
        end else if (shift_en_o) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOCKED: begin
        if (sel_fall_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end else if (sel_lvl_i) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o    = in_shift;
  assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/sfr_shift_reg.sv
module sfr_shift_reg
  import sfr_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_en_i,
  input  logic              done_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] next_word;

  assign next_word = shift_in(shreg_q, din_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (clear_i || done_i) shreg_q <= '0;
      else if (shift_en_i)   shreg_q <= next_word;
      if (done_i) word_o <= next_word;
    end
  end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              busy_o
);

  localparam int IDX_SEL  = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_DATA = 2;

  logic [2:0]       lines_s;
  logic             sel_fall_evt;
  logic             sclk_fall_evt;
  logic             shift_evt;
  logic             done_evt;
  logic             abort_evt;
  logic [CNT_W-1:0] bit_cnt;

  sfr_sync #(
    .LINES  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sdata_i, sclk_i, sel_n_i}),
    .sync_o (lines_s)
  );

  sfr_fall_det #(.RST_VAL(1'b1)) sel_det_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lines_s[IDX_SEL]),
    .fall_o(sel_fall_evt)
  );

  sfr_fall_det #(.RST_VAL(1'b1)) sclk_det_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lines_s[IDX_SCLK]),
    .fall_o(sclk_fall_evt)
  );

  sfr_frame_fsm #(.WORD_W(WORD_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lvl_i  (lines_s[IDX_SEL]),
    .sel_fall_i (sel_fall_evt),
    .sclk_fall_i(sclk_fall_evt),
    .shift_en_o (shift_evt),
    .done_o     (done_evt),
    .abort_o    (abort_evt),
    .busy_o     (busy_o),
    .bit_cnt_o  (bit_cnt)
  );

  sfr_shift_reg #(.WORD_W(WORD_W)) shreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (sel_fall_evt | abort_evt),
    .shift_en_i(shift_evt),
    .done_i    (done_evt),
    .din_i     (lines_s[IDX_DATA]),
    .word_o    (word_o),
    .valid_o   (word_valid_o)
  );

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              busy_o,
  input logic              sel_fall_evt,
  input logic              abort_evt,
  input logic [CNT_W-1:0]  bit_cnt
);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  assert_abort_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !word_valid_o);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(sel_fall_evt));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (word_valid_o || $past(abort_evt)));

  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (bit_cnt == '0));

  assert_strobe_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(busy_o));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) < WORD_W);

endmodule

bind serial_frame_rx sfr_checker #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .busy_o      (busy_o),
  .sel_fall_evt(sel_fall_evt),
  .abort_evt   (abort_evt),
  .bit_cnt     (bit_cnt)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SER   = 4;      // system cycles per serial half period
  localparam int LATENCY    = 3;      // pins -> outputs, in system cycles
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdata = 1'b0;
  logic [23:0] word;
  logic        valid;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_rx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n_i     (sel_n),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .word_o      (word),
    .word_valid_o(valid),
    .busy_o      (busy)
  );

  always @(negedge clk) if (rst_n && valid) strobes++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit: data set, falling clock edge, rising clock edge.
  task automatic ser_bit(input logic b);
    sdata = b;
    wait_cyc(HALF_SER);
    sclk = 1'b0;
    wait_cyc(HALF_SER);
    sclk = 1'b1;
  endtask

  task automatic open_frame();
    @(negedge clk);
    sel_n = 1'b0;
    wait_cyc(HALF_SER);
  endtask

  task automatic close_frame();
    wait_cyc(HALF_SER);
    sel_n = 1'b1;
    wait_cyc(HALF_SER * 2);
  endtask

  // Full frame with exact-cycle checks on the strobe.
  task automatic t_full_frame(input logic [23:0] w, input string tag);
    int s0;
    open_frame();
    for (int i = 23; i >= 1; i--) ser_bit(w[i]);
    sdata = w[0];
    wait_cyc(HALF_SER);
    s0 = strobes;
    sclk = 1'b0;                         // 24th falling edge
    wait_cyc(LATENCY - 1);
    chk(valid == 1'b0, {tag, " R4 no early strobe"}, valid, 0);
    wait_cyc(1);
    chk(valid == 1'b1, {tag, " R4 strobe with select low"}, valid, 1);
    chk(word == w, {tag, " R2 R3 word"}, word, w);
    chk(busy == 1'b0, {tag, " R8 busy clear at completion"}, busy, 0);
    wait_cyc(1);
    chk(valid == 1'b0, {tag, " R3 single-cycle strobe"}, valid, 0);
    chk(strobes - s0 == 1, {tag, " R3 one strobe"}, strobes - s0, 1);
    wait_cyc(HALF_SER);
    sclk = 1'b1;
    close_frame();
    chk(word == w, {tag, " R3 word held"}, word, w);
  endtask

  task automatic t_reset();
    chk(word == 24'h0, "R1 word after reset", word, 0);
    chk(valid == 1'b0, "R1 strobe after reset", valid, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_busy_window();
    logic [23:0] w = 24'h3C5A96;
    chk(busy == 1'b0, "R8 busy low before select", busy, 0);
    @(negedge clk);
    sel_n = 1'b0;
    wait_cyc(LATENCY - 1);
    chk(busy == 1'b0, "R8 busy not yet", busy, 0);
    wait_cyc(1);
    chk(busy == 1'b1, "R8 busy after select fall", busy, 1);
    wait_cyc(HALF_SER - LATENCY);
    for (int i = 23; i >= 0; i--) begin
      ser_bit(w[i]);
      if (i == 12) chk(busy == 1'b1, "R8 busy mid-frame", busy, 1);
    end
    wait_cyc(LATENCY);
    chk(busy == 1'b0, "R8 busy after completion", busy, 0);
    chk(word == w, "R3 word of busy frame", word, w);
    close_frame();
  endtask

  task automatic t_extra_clocks();
    logic [23:0] w = 24'hA1B2C3;
    int s0 = strobes;
    open_frame();
    for (int i = 23; i >= 0; i--) ser_bit(w[i]);
    for (int k = 0; k < 8; k++) ser_bit(k[0]);
    wait_cyc(LATENCY + 2);
    chk(word == w, "R5 trailing clocks ignored", word, w);
    chk(strobes - s0 == 1, "R5 no extra strobe", strobes - s0, 1);
    wait_cyc(40);                        // frame held locked, select low
    chk(strobes - s0 == 1, "R7 locked frame gives no second strobe", strobes - s0, 1);
    close_frame();
  endtask

  task automatic t_abort(input int nbits, input logic [23:0] junk, input logic [23:0] next_w);
    logic [23:0] prev = word;
    int s0 = strobes;
    open_frame();
    for (int i = 0; i < nbits; i++) ser_bit(junk[23-i]);
    sel_n = 1'b1;
    wait_cyc(LATENCY + 2);
    chk(strobes == s0, "R6 abort gives no strobe", strobes - s0, 0);
    chk(word == prev, "R6 word kept after abort", word, prev);
    chk(busy == 1'b0, "R8 busy clear after abort", busy, 0);
    wait_cyc(HALF_SER);
    t_full_frame(next_w, "R6 frame after abort");
  endtask

  task automatic t_idle_clocks();
    logic [23:0] prev = word;
    int s0 = strobes;
    for (int k = 0; k < 30; k++) ser_bit(1'b1);
    wait_cyc(LATENCY + 2);
    chk(strobes == s0, "R7 clocks with select high", strobes - s0, 0);
    chk(word == prev, "R7 word unchanged while idle", word, prev);
    chk(busy == 1'b0, "R7 not busy while idle", busy, 0);
  endtask

  initial begin : wdog
    int n = 0;
    while (!finished) begin
      @(posedge clk);
      n++;
      if (n > WD_LIMIT) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", n, WD_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_full_frame(24'hD2E1F7, "R2 mixed");
    t_full_frame(24'h800000, "R2 msb only");
    t_full_frame(24'h000001, "R2 lsb only");
    t_full_frame(24'hFFFFFF, "R3 all ones");
    t_busy_window();
    t_extra_clocks();
    t_abort(10, 24'hFFFFFF, 24'h123456);
    t_abort(23, 24'hFFFFFF, 24'h0F0F0E);
    t_idle_clocks();
    t_full_frame(24'h000000, "R3 all zeros");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule